// File: doc/BRIEF.md
# Sign-Extending Accumulator Register

This block holds the result of a multiply-accumulate unit. The meaningful part of the value is 56 bits wide, but the register presents a 64-bit view to software and to the datapath. The register keeps every bit that was written, including the top byte. Every read derives its value from bit 55: the top byte of a read always carries copies of that bit, whatever the stored top byte holds.

Writers can replace the whole 64-bit word at once, or replace only the upper or the lower 32-bit word while the other word is kept. Readers see the full sign-extended word and its two 32-bit halves on separate outputs at all times. The multiply-accumulate datapath that produces the values sits outside this block.

The write strobes are plain enables with no back-pressure. The register accepts every strobe in the cycle it arrives, so it offers no ready signal. A write is visible on the read outputs after the next rising clock edge. Reads are combinational from the stored word.

Top module: `sext_acc_reg`

## Requirements
- R1: With no write strobe active, the stored word, including its top byte, stays unchanged from one cycle to the next.
- R2: When `wr_all_en` is sampled high, bits 55:0 of `rd_all` equal bits 55:0 of `wr_all_data` from the next cycle on.
- R3: Bits 63:56 of `rd_all` are always copies of bit 55 of the stored word, and bits 55:0 of `rd_all` equal bits 55:0 of the stored word.
- R4: A write through `wr_lo_en` alone replaces stored bits 31:0 and leaves stored bits 63:32 unchanged.
- R5: A write through `wr_hi_en` alone replaces stored bits 63:32 and leaves stored bits 31:0 unchanged. Bit 23 of `wr_hi_data` becomes the sign bit (bit 55).
- R6: `rd_hi` equals bits 63:32 of the sign-extended value on `rd_all`.
- R7: `rd_lo` equals bits 31:0 of the stored word, which are also bits 31:0 of `rd_all`.
- R8: A synchronous active-high `rst` clears the stored word to zero.
- R9: When `wr_all_en` is high in the same cycle as either half-word strobe, only the full write takes effect.
- R10: When `wr_hi_en` and `wr_lo_en` are both high without `wr_all_en`, both halves are replaced in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_all_en | input | 1 | Strobe for a full-word write |
| wr_all_data | input | 64 | Data for a full-word write |
| wr_hi_en | input | 1 | Strobe for an upper-word write |
| wr_hi_data | input | 32 | Data for stored bits 63:32 |
| wr_lo_en | input | 1 | Strobe for a lower-word write |
| wr_lo_data | input | 32 | Data for stored bits 31:0 |
| rd_all | output | 64 | Stored word sign-extended from bit 55 |
| rd_hi | output | 32 | Upper half of the sign-extended word |
| rd_lo | output | 32 | Lower half of the sign-extended word |

## Verification
The assertions assume that the strobes and the data buses carry known values in every cycle after reset, and that a strobe lasts exactly the cycles in which its write is meant to happen. The bench drives all inputs on the falling edge and returns every strobe to zero after one cycle, so no write spills into a later cycle. It keeps the data buses at defined values throughout. This includes data with a set top byte and a clear bit 55, so that the split between the stored byte and the read view is exercised.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

  // Which source feeds the accumulator in a given cycle.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_FULL   = 2'd1,
    SRC_HALVES = 2'd2
  } sacc_src_e;

  // Sign-extension variants selectable per instance.
  localparam int EXT_REPLICATE = 0;
  localparam int EXT_ARITH     = 1;

endpackage

// File: rtl/sacc_wr_merge.sv
module sacc_wr_merge
  import sacc_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] cur_q,
  input  logic              all_en,
  input  logic [DATA_W-1:0] all_data,
  input  logic              hi_en,
  input  logic [HALF_W-1:0] hi_data,
  input  logic              lo_en,
  input  logic [HALF_W-1:0] lo_data,
  output logic              load,
  output logic [DATA_W-1:0] nxt
);

  sacc_src_e src;

  // Full write wins; otherwise each half strobe patches its own word.
  always_comb begin
    if (all_en)               src = SRC_FULL;
    else if (hi_en || lo_en)  src = SRC_HALVES;
    else                      src = SRC_NONE;
  end

  always_comb begin
    nxt = cur_q;
    unique case (src)
      SRC_FULL: nxt = all_data;
      SRC_HALVES: begin
        if (hi_en) nxt[DATA_W-1:HALF_W] = hi_data;
        if (lo_en) nxt[HALF_W-1:0]      = lo_data;
      end
      default: nxt = cur_q;
    endcase
  end

  assign load = (src != SRC_NONE);

endmodule

// File: rtl/sacc_store.sv
module sacc_store #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/sacc_sign_view.sv
module sacc_sign_view
  import sacc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SIGN_BIT = 55,   // must be below DATA_W-1
  parameter int EXT_MODE = EXT_ARITH
) (
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] ext
);

  localparam int KEEP_W = SIGN_BIT + 1;
  localparam int TOP_W  = DATA_W - KEEP_W;

  generate
    if (EXT_MODE == EXT_ARITH) begin : g_arith
      // Clear the top, flip the sign bit, then take the sign weight back off.
      localparam logic [DATA_W-1:0] KEEP_MASK = {{TOP_W{1'b0}}, {KEEP_W{1'b1}}};
      localparam logic [DATA_W-1:0] SIGN_WT   = {{TOP_W{1'b0}}, 1'b1, {SIGN_BIT{1'b0}}};
      logic [DATA_W-1:0] flipped;
      assign flipped = (raw & KEEP_MASK) ^ SIGN_WT;
      assign ext     = flipped - SIGN_WT;
    end else begin : g_repl
      assign ext = {{TOP_W{raw[SIGN_BIT]}}, raw[SIGN_BIT:0]};
    end
  endgenerate

endmodule

// File: rtl/sext_acc_reg.sv
module sext_acc_reg
  import sacc_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SIGN_BIT = 55,
  parameter int EXT_MODE = EXT_ARITH,
  localparam int HALF_W  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_all_en,
  input  logic [DATA_W-1:0] wr_all_data,
  input  logic              wr_hi_en,
  input  logic [HALF_W-1:0] wr_hi_data,
  input  logic              wr_lo_en,
  input  logic [HALF_W-1:0] wr_lo_data,
  output logic [DATA_W-1:0] rd_all,
  output logic [HALF_W-1:0] rd_hi,
  output logic [HALF_W-1:0] rd_lo
);

  localparam int TOP_W = DATA_W - SIGN_BIT - 1;

  logic              load;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] view;

  sacc_wr_merge #(.DATA_W(DATA_W)) u_merge (
    .cur_q   (acc_q),
    .all_en  (wr_all_en),
    .all_data(wr_all_data),
    .hi_en   (wr_hi_en),
    .hi_data (wr_hi_data),
    .lo_en   (wr_lo_en),
    .lo_data (wr_lo_data),
    .load    (load),
    .nxt     (nxt)
  );

  sacc_store #(.DATA_W(DATA_W)) u_store (
    .clk (clk),
    .rst (rst),
    .load(load),
    .d   (nxt),
    .q   (acc_q)
  );

  sacc_sign_view #(
    .DATA_W  (DATA_W),
    .SIGN_BIT(SIGN_BIT),
    .EXT_MODE(EXT_MODE)
  ) u_view (
    .raw(acc_q),
    .ext(view)
  );

  assign rd_all = view;
  assign rd_hi  = view[DATA_W-1:HALF_W];
  assign rd_lo  = view[HALF_W-1:0];

  // R1: idle cycles leave the whole stored word alone
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!wr_all_en && !wr_hi_en && !wr_lo_en) |=> $stable(acc_q));

  // R2: a full write lands in the low 56 bits of the read view
  p_full_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_all_en |=> (rd_all[SIGN_BIT:0] == $past(wr_all_data[SIGN_BIT:0])));

  // R3: the read top byte follows the stored sign bit
  p_top_copies_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_all[DATA_W-1:SIGN_BIT+1] == {TOP_W{acc_q[SIGN_BIT]}}) &&
    (rd_all[SIGN_BIT:0] == acc_q[SIGN_BIT:0]));

  // R4: a lone low write keeps the upper stored word
  p_lo_keeps_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_lo_en && !wr_hi_en && !wr_all_en) |=>
      (acc_q[DATA_W-1:HALF_W] == $past(acc_q[DATA_W-1:HALF_W])) &&
      (acc_q[HALF_W-1:0] == $past(wr_lo_data)));

  // R5: a lone high write keeps the lower stored word
  p_hi_keeps_lo_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_hi_en && !wr_lo_en && !wr_all_en) |=>
      (acc_q[HALF_W-1:0] == $past(acc_q[HALF_W-1:0])) &&
      (acc_q[DATA_W-1:HALF_W] == $past(wr_hi_data)));

  // R8: reset clears the word
  p_reset_zero_r8: assert property (@(posedge clk)
    rst |=> (acc_q == '0));

  // R9: full write overrides concurrent half writes
  p_full_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_all_en && (wr_hi_en || wr_lo_en)) |=> (acc_q == $past(wr_all_data)));

  // R10: both half writes together replace the whole word
  p_both_halves_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_hi_en && wr_lo_en && !wr_all_en) |=>
      (acc_q == {$past(wr_hi_data), $past(wr_lo_data)}));

endmodule

// File: tb/sext_acc_reg_test.sv
`timescale 1ns/1ps
module sext_acc_reg_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_all_en;
  logic [63:0] wr_all_data;
  logic        wr_hi_en;
  logic [31:0] wr_hi_data;
  logic        wr_lo_en;
  logic [31:0] wr_lo_data;
  logic [63:0] rd_all;
  logic [31:0] rd_hi;
  logic [31:0] rd_lo;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic [63:0] model;

  always #2 clk = ~clk;

  sext_acc_reg uut (
    .clk(clk), .rst(rst),
    .wr_all_en(wr_all_en), .wr_all_data(wr_all_data),
    .wr_hi_en(wr_hi_en), .wr_hi_data(wr_hi_data),
    .wr_lo_en(wr_lo_en), .wr_lo_data(wr_lo_data),
    .rd_all(rd_all), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  function automatic logic [63:0] sx(input logic [63:0] v);
    return {{8{v[55]}}, v[55:0]};
  endfunction

  task automatic check_reads(input string req);
    logic [63:0] e;
    e = sx(model);
    checks++;
    if (rd_all !== e || rd_hi !== e[63:32] || rd_lo !== e[31:0]) begin
      failures++;
      $display("FAIL %s: actual all=%h hi=%h lo=%h expected all=%h hi=%h lo=%h",
               req, rd_all, rd_hi, rd_lo, e, e[63:32], e[31:0]);
    end
  endtask

  // Drive one cycle of strobes at the falling edge, then clear them.
  task automatic wr(input logic fa, input logic [63:0] da,
                    input logic fh, input logic [31:0] dh,
                    input logic fl, input logic [31:0] dl);
    @(negedge clk);
    wr_all_en = fa; wr_all_data = da;
    wr_hi_en = fh;  wr_hi_data = dh;
    wr_lo_en = fl;  wr_lo_data = dl;
    if (fa) model = da;
    else begin
      if (fh) model[63:32] = dh;
      if (fl) model[31:0]  = dl;
    end
    @(negedge clk);
    wr_all_en = 1'b0; wr_hi_en = 1'b0; wr_lo_en = 1'b0;
  endtask

  task automatic t_reset;
    wr(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0, 1'b0, '0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model = '0;
    check_reads("R8");
  endtask

  task automatic t_full;
    wr(1'b1, 64'h007F_1234_5678_9ABC, 1'b0, '0, 1'b0, '0);
    check_reads("R2");
    wr(1'b1, 64'hA512_3456_789A_BCDE, 1'b0, '0, 1'b0, '0);
    check_reads("R3 top byte set, bit55 clear");
    wr(1'b1, 64'h0080_0000_0000_0001, 1'b0, '0, 1'b0, '0);
    check_reads("R3 top byte clear, bit55 set");
  endtask

  task automatic t_halves;
    wr(1'b1, 64'h00C0_0000_1111_2222, 1'b0, '0, 1'b0, '0);
    wr(1'b0, '0, 1'b0, '0, 1'b1, 32'hDEAD_BEEF);
    check_reads("R4 R7");
    wr(1'b0, '0, 1'b1, 32'h8000_0000, 1'b0, '0);
    check_reads("R5 R6 hi bit23 clear");
    wr(1'b0, '0, 1'b1, 32'h0080_1234, 1'b0, '0);
    check_reads("R5 R6 hi bit23 set");
    wr(1'b0, '0, 1'b0, '0, 1'b1, 32'h0000_0005);
    check_reads("R4 after signed high");
  endtask

  task automatic t_priority;
    wr(1'b1, 64'h0012_3456_0000_00AA, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF);
    check_reads("R9 all three strobes");
    wr(1'b1, 64'h00FF_0000_0000_0001, 1'b0, '0, 1'b1, 32'h7777_7777);
    check_reads("R9 full with low");
    wr(1'b0, '0, 1'b1, 32'h00AB_CDEF, 1'b1, 32'h0102_0304);
    check_reads("R10 both halves");
  endtask

  task automatic t_hold;
    wr(1'b1, 64'h1E80_0000_4242_4242, 1'b0, '0, 1'b0, '0);
    repeat (3) @(negedge clk);
    check_reads("R1 idle hold");
    wr(1'b0, '0, 1'b0, '0, 1'b1, 32'h0);
    check_reads("R1 stored top byte untouched by low write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; model = '0;
    wr_all_en = 1'b0; wr_all_data = '0;
    wr_hi_en = 1'b0;  wr_hi_data = '0;
    wr_lo_en = 1'b0;  wr_lo_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reads("R8 initial");
    t_full;
    t_halves;
    t_priority;
    t_hold;
    t_reset;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule